// File: doc/BRIEF.md
# Daisy-Chain Node Enumeration and Relay

This block is one node in a serial chain of monitoring devices. It sits between two message ports. The host-facing side carries frames travelling away from the host. The far side carries them on to the next node. A second pair of ports carries returning frames back toward the host. All frames arrive already decoded into command, device address, register address and data fields, and each port uses a valid/ready handshake.

A node starts asleep and unenumerated. Any frame that reaches it wakes it. While it holds no address, or its relay switch is off, it passes nothing on except wake-up frames that it generates itself. The host assigns the address and turns on relaying with a write to a configuration register. From then on every frame travels through the node. Frames that name this node are also handed to local register logic on a one-cycle strobe. Wake-up frames are regenerated so that a pair of host wake-ups ripples down the whole chain: a relaying node adds one copy, and a non-relaying node emits two. Self-made wake-ups are spaced by a parameterised gap.

Top module: `dcn_node`

## Requirements
- R1: After reset, `awake`, `node_addr`, `fwd_on`, `ds_out_valid` and `us_out_valid` are all 0 and `ds_in_ready` is 1.
- R2: A far-bound frame accepted while asleep is taken only as a wake event. `awake` is 1 one cycle later, and the frame shows up neither on `ds_out` nor on `loc_valid`.
- R3: A write (cmd 2) to register `CFG_REG` whose device field equals `node_addr` loads `node_addr` from data bits [5:0] and `fwd_on` from data bit 9, visible the next cycle. The write is ignored when bits [5:0] are 0 or exceed `MAX_NODES`.
- R4: Every accepted non-wake frame (cmd not 0) whose device field equals `node_addr` raises `loc_valid` for one cycle, one cycle after acceptance, with that frame's cmd, register and data.
- R5: While not relaying (`node_addr` is 0 or `fwd_on` is 0), `ds_out` carries only self-made wake-ups, and both `us_in_ready` and `us_out_valid` are 0.
- R6: While relaying, every accepted non-wake frame appears unchanged on `ds_out` one cycle after acceptance, whether or not it is addressed to this node.
- R7: While relaying, an accepted wake-up (cmd 0) is passed on unchanged one cycle after acceptance. One extra wake-up frame (all fields 0) follows exactly `WAKE_GAP` cycles later when the far side is ready.
- R8: While awake but not relaying, an accepted wake-up produces two wake-up frames (all fields 0). The first appears two cycles after acceptance and the second `WAKE_GAP` cycles after the first.
- R9: `ds_in_ready` stays 0 while self-made wake-ups are still owed, and returns to 1 once the last has left.
- R10: While relaying, returning frames pass combinationally from `us_in` to `us_out` unchanged, with `us_out_ready` returned on `us_in_ready`. A write never causes any returning frame.
- R11: A frame on `ds_out` held with `ds_out_ready` low keeps every field stable, and `ds_in_ready` stays 0 meanwhile.
- R12: A `sleep_req` pulse returns the node to the R1 state at the next edge and cancels any wake-ups still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Pulse: go to sleep, drop address and relay state |
| ds_in_valid | input | 1 | Far-bound frame from host side is valid |
| ds_in_ready | output | 1 | Node accepts the far-bound frame |
| ds_in_cmd | input | 2 | Command: 0 wake, 1 read, 2 write, 3 response |
| ds_in_dev | input | 6 | Target device address |
| ds_in_reg | input | 14 | Register address |
| ds_in_data | input | 16 | Data word |
| ds_out_valid | output | 1 | Far-bound frame to next node is valid |
| ds_out_ready | input | 1 | Next node accepts the frame |
| ds_out_cmd | output | 2 | Command |
| ds_out_dev | output | 6 | Device address |
| ds_out_reg | output | 14 | Register address |
| ds_out_data | output | 16 | Data word |
| us_in_valid | input | 1 | Returning frame from next node is valid |
| us_in_ready | output | 1 | Node accepts the returning frame |
| us_in_cmd | input | 2 | Command |
| us_in_dev | input | 6 | Device address |
| us_in_reg | input | 14 | Register address |
| us_in_data | input | 16 | Data word |
| us_out_valid | output | 1 | Returning frame toward host is valid |
| us_out_ready | input | 1 | Host side accepts the returning frame |
| us_out_cmd | output | 2 | Command |
| us_out_dev | output | 6 | Device address |
| us_out_reg | output | 14 | Register address |
| us_out_data | output | 16 | Data word |
| loc_valid | output | 1 | One-cycle strobe: frame addressed to this node |
| loc_cmd | output | 2 | Command of the local frame |
| loc_reg | output | 14 | Register address of the local frame |
| loc_data | output | 16 | Data of the local frame |
| node_addr | output | 6 | Current node address, 0 when unenumerated |
| fwd_on | output | 1 | Relay switch state |
| awake | output | 1 | Node is awake |

## Verification
The returning path is combinational, so the bench checks it a moment after driving it in the same cycle. Forwarded frames, the `loc_valid` strobe and updates to `awake`, `node_addr` and `fwd_on` all become visible one cycle after the accepting edge. A self-made wake-up starts two cycles after acceptance when not relaying. Each later wake-up lands exactly `WAKE_GAP` cycles after the previous wake frame. The bench drives on the falling edge and samples at the first falling edge after the accepting rising edge. It then counts falling edges to the next wake-up, so every expected value is tied to its cycle and not polled.

// File: rtl/dcn_pkg.sv
// Shared field widths, command codes and the frame record used by the
// daisy-chain node. Assumes frames arrive fully decoded (no CRC here).
package dcn_pkg;
    localparam int DEV_W = 6;
    localparam int REG_W = 14;
    localparam int DAT_W = 16;

    typedef enum logic [1:0] {
        CMD_WAKE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RESP  = 2'd3
    } cmd_e;

    typedef struct packed {
        cmd_e               cmd;
        logic [DEV_W-1:0]   dev;
        logic [REG_W-1:0]   rega;
        logic [DAT_W-1:0]   data;
    } frame_t;
endpackage

// File: rtl/dcn_cfg_reg.sv
// Node state: awake flag, chain address and relay switch.
// Assumes cfg_we is already qualified (addressed write to the config
// register); this module only range-checks the new address.
module dcn_cfg_reg
    import dcn_pkg::*;
#(
    parameter int MAX_NODES = 62,
    parameter int FWD_BIT   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_evt,
    input  logic             cfg_we,
    input  logic [DAT_W-1:0] cfg_data,
    output logic             awake,
    output logic [DEV_W-1:0] node_addr,
    output logic             fwd_on
);
    logic [DEV_W-1:0] new_addr;
    logic             addr_ok;

    // Address candidate and its legal range (1..MAX_NODES).
    always_comb begin
        new_addr = cfg_data[DEV_W-1:0];
        addr_ok  = (new_addr != '0) && (32'(new_addr) <= 32'(MAX_NODES));
    end

    // State register; sleep has priority over any update.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_req) begin
            awake     <= 1'b0;
            node_addr <= '0;
            fwd_on    <= 1'b0;
        end else begin
            if (wake_evt) begin
                awake <= 1'b1;
            end
            if (cfg_we && addr_ok) begin
                node_addr <= new_addr;
                fwd_on    <= cfg_data[FWD_BIT];
            end
        end
    end
endmodule

// File: rtl/dcn_wake_gen.sv
// Wake-up regeneration scheduler: counts owed wake frames and enforces a
// minimum spacing of WAKE_GAP cycles between wake frame launches.
// Assumes WAKE_GAP >= 1 and that load_en only fires while nothing is owed.
module dcn_wake_gen #(
    parameter int WAKE_GAP = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       load_en,
    input  logic [1:0] load_cnt,
    input  logic       launch,
    input  logic       slot_free,
    output logic       busy,
    output logic       regen_go
);
    localparam int GAP_W = $clog2(WAKE_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(WAKE_GAP - 1);

    logic [1:0]       owed;
    logic [GAP_W-1:0] gap_left;

    // Launch a self-made wake once the gap has run out and the slot is free.
    always_comb begin
        busy     = (owed != 2'd0);
        regen_go = busy && (gap_left == '0) && slot_free;
    end

    // Owed count and spacing timer.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_req) begin
            owed     <= 2'd0;
            gap_left <= '0;
        end else begin
            if (load_en) begin
                owed <= load_cnt;
            end else if (regen_go) begin
                owed <= owed - 2'd1;
            end
            if (launch) begin
                gap_left <= GAP_RELOAD;
            end else if (gap_left != '0) begin
                gap_left <= gap_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcn_dn_path.sv
// Far-bound path: classifies each accepted frame (wake event, local hit,
// relay, wake regeneration request), owns the one-entry output register and
// the local strobe register. Assumes the wake scheduler blocks new input
// while regenerated frames are owed.
module dcn_dn_path
    import dcn_pkg::*;
#(
    parameter logic [REG_W-1:0] CFG_REG = 14'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             awake,
    input  logic [DEV_W-1:0] node_addr,
    input  logic             fwd_on,
    input  logic             in_valid,
    output logic             in_ready,
    input  frame_t           in_frame,
    output logic             out_valid,
    input  logic             out_ready,
    output frame_t           out_frame,
    input  logic             wake_busy,
    input  logic             regen_go,
    output logic             slot_free,
    output logic             wake_evt,
    output logic             cfg_we,
    output logic             load_en,
    output logic [1:0]       load_cnt,
    output logic             launch,
    output logic             loc_valid,
    output frame_t           loc_frame
);
    localparam frame_t WAKE_FRAME = '{cmd: CMD_WAKE, dev: '0, rega: '0, data: '0};

    logic relay, accept, take, is_wake, hit, fwd_go;

    // Frame classification and handshake.
    always_comb begin
        relay     = (node_addr != '0) && fwd_on;
        slot_free = !out_valid || out_ready;
        in_ready  = slot_free && !wake_busy;
        accept    = in_valid && in_ready;
        is_wake   = (in_frame.cmd == CMD_WAKE);
        hit       = (in_frame.dev == node_addr) && !is_wake;
        wake_evt  = accept && !awake;
        take      = accept && awake;
        fwd_go    = take && relay;
        cfg_we    = take && hit && (in_frame.cmd == CMD_WRITE) && (in_frame.rega == CFG_REG);
        load_en   = take && is_wake;
        load_cnt  = relay ? 2'd1 : 2'd2;
        launch    = (fwd_go && is_wake) || regen_go;
    end

    // One-entry output register toward the next node.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_req) begin
            out_valid <= 1'b0;
            out_frame <= WAKE_FRAME;
        end else if (fwd_go) begin
            out_valid <= 1'b1;
            out_frame <= in_frame;
        end else if (regen_go) begin
            out_valid <= 1'b1;
            out_frame <= WAKE_FRAME;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Local strobe for frames addressed to this node.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_req) begin
            loc_valid <= 1'b0;
            loc_frame <= WAKE_FRAME;
        end else begin
            loc_valid <= take && hit;
            if (take && hit) begin
                loc_frame <= in_frame;
            end
        end
    end
endmodule

// File: rtl/dcn_node.sv
// Top of one chain node: wires the far-bound path, the wake scheduler and
// the node state, and relays returning frames while relaying is enabled.
// Assumes ports carry decoded frames; the return path adds no latency.
module dcn_node
    import dcn_pkg::*;
#(
    parameter int               MAX_NODES = 62,
    parameter int               WAKE_GAP  = 16,
    parameter logic [13:0]      CFG_REG   = 14'h0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_req,
    input  logic        ds_in_valid,
    output logic        ds_in_ready,
    input  logic [1:0]  ds_in_cmd,
    input  logic [5:0]  ds_in_dev,
    input  logic [13:0] ds_in_reg,
    input  logic [15:0] ds_in_data,
    output logic        ds_out_valid,
    input  logic        ds_out_ready,
    output logic [1:0]  ds_out_cmd,
    output logic [5:0]  ds_out_dev,
    output logic [13:0] ds_out_reg,
    output logic [15:0] ds_out_data,
    input  logic        us_in_valid,
    output logic        us_in_ready,
    input  logic [1:0]  us_in_cmd,
    input  logic [5:0]  us_in_dev,
    input  logic [13:0] us_in_reg,
    input  logic [15:0] us_in_data,
    output logic        us_out_valid,
    input  logic        us_out_ready,
    output logic [1:0]  us_out_cmd,
    output logic [5:0]  us_out_dev,
    output logic [13:0] us_out_reg,
    output logic [15:0] us_out_data,
    output logic        loc_valid,
    output logic [1:0]  loc_cmd,
    output logic [13:0] loc_reg,
    output logic [15:0] loc_data,
    output logic [5:0]  node_addr,
    output logic        fwd_on,
    output logic        awake
);
    frame_t     in_frame, out_frame, loc_frame;
    logic       wake_busy, regen_go, slot_free, wake_evt, cfg_we;
    logic       load_en, launch;
    logic [1:0] load_cnt;
    logic       relay;

    // Port fields to and from the frame record.
    always_comb begin
        in_frame    = '{cmd: cmd_e'(ds_in_cmd), dev: ds_in_dev, rega: ds_in_reg, data: ds_in_data};
        ds_out_cmd  = out_frame.cmd;
        ds_out_dev  = out_frame.dev;
        ds_out_reg  = out_frame.rega;
        ds_out_data = out_frame.data;
        loc_cmd     = loc_frame.cmd;
        loc_reg     = loc_frame.rega;
        loc_data    = loc_frame.data;
    end

    // Return path: pass through only while relaying.
    always_comb begin
        relay        = (node_addr != '0) && fwd_on;
        us_out_valid = relay && us_in_valid;
        us_in_ready  = relay && us_out_ready;
        us_out_cmd   = us_in_cmd;
        us_out_dev   = us_in_dev;
        us_out_reg   = us_in_reg;
        us_out_data  = us_in_data;
    end

    dcn_dn_path #(.CFG_REG(CFG_REG)) u_dn (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .awake(awake),
        .node_addr(node_addr), .fwd_on(fwd_on),
        .in_valid(ds_in_valid), .in_ready(ds_in_ready), .in_frame(in_frame),
        .out_valid(ds_out_valid), .out_ready(ds_out_ready), .out_frame(out_frame),
        .wake_busy(wake_busy), .regen_go(regen_go), .slot_free(slot_free),
        .wake_evt(wake_evt), .cfg_we(cfg_we), .load_en(load_en), .load_cnt(load_cnt),
        .launch(launch), .loc_valid(loc_valid), .loc_frame(loc_frame)
    );

    dcn_wake_gen #(.WAKE_GAP(WAKE_GAP)) u_wake (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .load_en(load_en),
        .load_cnt(load_cnt), .launch(launch), .slot_free(slot_free),
        .busy(wake_busy), .regen_go(regen_go)
    );

    dcn_cfg_reg #(.MAX_NODES(MAX_NODES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .cfg_we(cfg_we), .cfg_data(ds_in_data), .awake(awake),
        .node_addr(node_addr), .fwd_on(fwd_on)
    );
endmodule

// File: rtl/dcn_node_chk.sv
// Port-level temporal checks for dcn_node, bound into every instance.
module dcn_node_chk #(
    parameter int MAX_NODES = 62
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep_req,
    input logic        awake,
    input logic [5:0]  node_addr,
    input logic        fwd_on,
    input logic        ds_in_ready,
    input logic        ds_out_valid,
    input logic        ds_out_ready,
    input logic [1:0]  ds_out_cmd,
    input logic [5:0]  ds_out_dev,
    input logic [13:0] ds_out_reg,
    input logic [15:0] ds_out_data,
    input logic        us_in_ready,
    input logic        us_out_valid,
    input logic        loc_valid
);
    logic relaying;
    assign relaying = (node_addr != 6'd0) && fwd_on;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!awake && node_addr == 6'd0 && !fwd_on && !ds_out_valid)); // R1
    AST_ASLEEP_NO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> !loc_valid); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(node_addr) <= 32'(MAX_NODES)); // R3
    AST_IDLE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !relaying |-> (!us_out_valid && !us_in_ready)); // R5
    AST_IDLE_ONLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_out_valid && !$past(ds_out_valid) && !$past(relaying)) |->
        (ds_out_cmd == 2'd0 && ds_out_dev == 6'd0)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_out_valid && !ds_out_ready && !sleep_req) |=>
        (ds_out_valid && $stable(ds_out_cmd) && $stable(ds_out_dev) &&
         $stable(ds_out_reg) && $stable(ds_out_data))); // R11
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_out_valid && !ds_out_ready) |-> !ds_in_ready); // R11
    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_req) |-> (!awake && node_addr == 6'd0 && !fwd_on && !ds_out_valid)); // R12
endmodule

bind dcn_node dcn_node_chk #(.MAX_NODES(MAX_NODES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .awake(awake),
    .node_addr(node_addr), .fwd_on(fwd_on), .ds_in_ready(ds_in_ready),
    .ds_out_valid(ds_out_valid), .ds_out_ready(ds_out_ready),
    .ds_out_cmd(ds_out_cmd), .ds_out_dev(ds_out_dev), .ds_out_reg(ds_out_reg),
    .ds_out_data(ds_out_data), .us_in_ready(us_in_ready),
    .us_out_valid(us_out_valid), .loc_valid(loc_valid)
);

// File: tb/dcn_node_tb.sv
module dcn_node_tb;
    localparam int          GAP = 6;
    localparam logic [13:0] CFG = 14'h0010;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, sleep_req = 1'b0;
    logic        ds_in_valid = 1'b0, ds_in_ready;
    logic [1:0]  ds_in_cmd = '0;
    logic [5:0]  ds_in_dev = '0;
    logic [13:0] ds_in_reg = '0;
    logic [15:0] ds_in_data = '0;
    logic        ds_out_valid, ds_out_ready = 1'b1;
    logic [1:0]  ds_out_cmd;
    logic [5:0]  ds_out_dev;
    logic [13:0] ds_out_reg;
    logic [15:0] ds_out_data;
    logic        us_in_valid = 1'b0, us_in_ready;
    logic [1:0]  us_in_cmd = '0;
    logic [5:0]  us_in_dev = '0;
    logic [13:0] us_in_reg = '0;
    logic [15:0] us_in_data = '0;
    logic        us_out_valid, us_out_ready = 1'b1;
    logic [1:0]  us_out_cmd;
    logic [5:0]  us_out_dev;
    logic [13:0] us_out_reg;
    logic [15:0] us_out_data;
    logic        loc_valid;
    logic [1:0]  loc_cmd;
    logic [13:0] loc_reg;
    logic [15:0] loc_data;
    logic [5:0]  node_addr;
    logic        fwd_on, awake;

    int errs = 0;
    int checks = 0;

    dcn_node #(.MAX_NODES(62), .WAKE_GAP(GAP), .CFG_REG(CFG)) u_dut (.*);

    task automatic eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [37:0] pack(input logic [1:0] c, input logic [5:0] d,
                                         input logic [13:0] r, input logic [15:0] x);
        return {c, d, r, x};
    endfunction

    function automatic logic [37:0] out_now();
        return {ds_out_cmd, ds_out_dev, ds_out_reg, ds_out_data};
    endfunction

    // Expected local strobe for a non-wake frame.
    function automatic logic exp_hit(input logic [1:0] c, input logic [5:0] d, input logic [5:0] a);
        return (c != 2'd0) && (d == a);
    endfunction

    // Drive one far-bound frame; returns at the falling edge after acceptance.
    task automatic send(input logic [1:0] c, input logic [5:0] d, input logic [13:0] r, input logic [15:0] x);
        @(negedge clk);
        ds_in_valid = 1'b1; ds_in_cmd = c; ds_in_dev = d; ds_in_reg = r; ds_in_data = x;
        while (!ds_in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ds_in_valid = 1'b0;
    endtask

    // Count falling edges until ds_out_valid, bounded.
    task automatic wait_out(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!ds_out_valid && k < 4 * GAP);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int k;
        int seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        eq("R1", "awake", awake, 0);
        eq("R1", "node_addr", node_addr, 0);
        eq("R1", "fwd_on", fwd_on, 0);
        eq("R1", "ds_out_valid", ds_out_valid, 0);
        eq("R1", "us_out_valid", us_out_valid, 0);
        eq("R1", "ds_in_ready", ds_in_ready, 1);

        // R2 wake from sleep with a read frame
        send(2'd1, 6'd0, 14'h0022, 16'h1111);
        eq("R2", "awake", awake, 1);
        eq("R2", "ds_out_valid", ds_out_valid, 0);
        eq("R2", "loc_valid", loc_valid, 0);

        // R5 return path closed while unenumerated
        us_in_valid = 1'b1; #1;
        eq("R5", "us_in_ready", us_in_ready, 0);
        eq("R5", "us_out_valid", us_out_valid, 0);
        us_in_valid = 1'b0;

        // R8/R9 unenumerated wake: two self-made wakes
        send(2'd0, 6'd9, 14'h0abc, 16'h5555);
        eq("R8", "no immediate forward", ds_out_valid, 0);
        eq("R9", "ds_in_ready while owed", ds_in_ready, 0);
        @(negedge clk);
        eq("R8", "first wake valid", ds_out_valid, 1);
        eq("R8", "first wake frame", out_now(), 0);
        wait_out(k);
        eq("R8", "second wake spacing", k, GAP);
        eq("R8", "second wake frame", out_now(), 0);
        @(negedge clk);
        eq("R9", "ds_in_ready after last", ds_in_ready, 1);

        // R3 illegal addresses are ignored; R4 local strobe; R5 no forward
        send(2'd2, 6'd0, CFG, 16'h0200);
        eq("R3", "addr 0 ignored", {node_addr, fwd_on}, 0);
        eq("R4", "loc_valid", loc_valid, 1);
        eq("R4", "loc frame", {loc_cmd, loc_reg, loc_data}, {2'd2, CFG, 16'h0200});
        eq("R5", "config not forwarded", ds_out_valid, 0);
        send(2'd2, 6'd0, CFG, 16'h023F);
        eq("R3", "addr 63 ignored", {node_addr, fwd_on}, 0);

        // R3 enumeration: address 5, relay on
        send(2'd2, 6'd0, CFG, 16'h0205);
        eq("R3", "node_addr", node_addr, 5);
        eq("R3", "fwd_on", fwd_on, 1);
        eq("R5", "own enumeration not forwarded", ds_out_valid, 0);

        // R6 enumeration write for a deeper node passes through
        send(2'd2, 6'd0, CFG, 16'h0202);
        eq("R6", "forward valid", ds_out_valid, 1);
        eq("R6", "forward frame", out_now(), pack(2'd2, 6'd0, CFG, 16'h0202));
        eq("R6", "no local hit", loc_valid, 0);
        eq("R3", "address kept", node_addr, 5);

        // R7 relay wake: forward then one extra after GAP
        send(2'd0, 6'd33, 14'h0123, 16'hBEEF);
        eq("R7", "forward wake", out_now(), pack(2'd0, 6'd33, 14'h0123, 16'hBEEF));
        eq("R7", "forward valid", ds_out_valid, 1);
        wait_out(k);
        eq("R7", "extra wake spacing", k, GAP);
        eq("R7", "extra wake frame", out_now(), 0);
        repeat (2) @(negedge clk);

        // R11 back-pressure hold
        ds_out_ready = 1'b0;
        send(2'd1, 6'd12, 14'h0456, 16'hA5A5);
        repeat (3) @(negedge clk);
        eq("R11", "held valid", ds_out_valid, 1);
        eq("R11", "held frame", out_now(), pack(2'd1, 6'd12, 14'h0456, 16'hA5A5));
        eq("R11", "input blocked", ds_in_ready, 0);
        ds_out_ready = 1'b1;
        @(negedge clk);

        // R10 return relay and no response to a write
        us_in_valid = 1'b1; us_in_cmd = 2'd3; us_in_dev = 6'd7; us_in_reg = 14'h0777; us_in_data = 16'h1234;
        us_out_ready = 1'b0; #1;
        eq("R10", "us_out frame", {us_out_valid, us_out_cmd, us_out_dev, us_out_reg, us_out_data},
           {1'b1, 2'd3, 6'd7, 14'h0777, 16'h1234});
        eq("R10", "ready follows", us_in_ready, 0);
        us_out_ready = 1'b1; #1;
        eq("R10", "ready follows high", us_in_ready, 1);
        us_in_valid = 1'b0;
        send(2'd2, 6'd5, 14'h0030, 16'h9999);
        eq("R4", "write hit", loc_valid, 1);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (us_out_valid) seen++;
            @(negedge clk);
        end
        eq("R10", "no response to write", seen, 0);

        // R6/R4 random relay traffic
        for (int n = 0; n < 40; n++) begin
            logic [1:0]  c;
            logic [5:0]  d;
            logic [13:0] r;
            logic [15:0] x;
            c = 2'(1 + $urandom_range(0, 2));
            d = ($urandom_range(0, 3) == 0) ? 6'd5 : 6'($urandom_range(0, 63));
            r = 14'($urandom);
            x = 16'($urandom);
            if (c == 2'd2 && r == CFG) r = CFG + 14'd1;
            send(c, d, r, x);
            eq("R6", "random forward", {ds_out_valid, out_now()}, {1'b1, pack(c, d, r, x)});
            eq("R4", "random local strobe", loc_valid, exp_hit(c, d, node_addr));
        end

        // R5 enumerated but relay off
        send(2'd2, 6'd5, CFG, 16'h0005);
        eq("R3", "relay off", {node_addr, fwd_on}, {6'd5, 1'b0});
        send(2'd1, 6'd5, 14'h0040, 16'h0000);
        eq("R4", "hit while relay off", loc_valid, 1);
        eq("R5", "no forward while relay off", ds_out_valid, 0);

        // R12 sleep cancels owed wakes
        send(2'd0, 6'd0, 14'h0000, 16'h0000);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        eq("R12", "state cleared", {awake, node_addr, fwd_on, ds_out_valid}, 0);
        seen = 0;
        for (int i = 0; i < GAP + 3; i++) begin
            if (ds_out_valid) seen++;
            @(negedge clk);
        end
        eq("R12", "no owed wake after sleep", seen, 0);
        eq("R12", "ready after sleep", ds_in_ready, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule